// File: doc/BRIEF.md
# Relocating Object Record Loader

This engine handles a single object-code record stored in byte-wide memory. The caller pulses a start strobe and supplies a 16-bit destination base and a pointer to the record. The engine reads a four-byte header and then takes one of three actions, chosen by the record's type byte. It may copy a payload of data bytes to a relocated destination. It may patch a list of 16-bit words by adding or subtracting the base. It may also recognise a terminating record and do no work on memory.

All memory traffic goes through one synchronous byte port. The port completes one access per cycle, and read data returns in the cycle after the read strobe. The engine keeps a running 8-bit checksum over every byte of the record, including a trailing check byte.

When the engine finishes, it reports four results: the relocated start address, a pointer to the byte after the record, three status flags (value V, link L, fault F) and a one-cycle done pulse. The caller supplies incoming link and fault values, and the engine either keeps or overrides them depending on the record type.

Top module: `objrec_loader`

## Requirements
- R1: The header is four bytes at the record pointer: type, length, address high, address low. At done, `start_addr` equals `base_addr + {address high, address low}` for every record type.
- R2: Type 0x80 is an end record. At done it gives V=1, L=1 and F=`fault_in`. It reads no payload, performs no checksum test, makes no memory write, and gives `next_ptr` = record pointer + 4.
- R3: Type 0x00 is a data record. It writes its `length` payload bytes in order to consecutive addresses starting at `start_addr`, and it writes nothing else.
- R4: A type 0x00 record with length 0 makes no write. At done it gives V=1, L=`link_in`, and F per R5.
- R5: For types 0x00, 0x01 and 0xFF, the engine adds modulo 256 the type, the length, both address bytes, every payload byte and the one check byte after the payload. F=1 when this sum is non-zero; otherwise F=`fault_in`.
- R6: For type 0x01 or 0xFF with an odd length, the engine makes no write. At done it gives F=1, V=0, L=`link_in` and `next_ptr` = record pointer + 4.
- R7: For type 0x01, the payload is a list of big-endian 2-byte offsets. For each offset, the engine reads the big-endian word at `base_addr` + offset (high byte at the lower address) and adds `base_addr` to it. It writes the high byte at the lower address first, then the low byte.
- R8: Type 0xFF does the same as R7, except that it subtracts `base_addr` from each word.
- R9: For a completed type 0x00, 0x01 or 0xFF record, `next_ptr` = record pointer + 5 + length, which is the byte after the check byte. V=0 unless R4 applies, and L=`link_in`.
- R10: Any other type value makes no write. At done it gives F=1, V=0, L=`link_in` and `next_ptr` = record pointer + 4.
- R11: `busy` rises in the cycle after an accepted start and stays high through the single-cycle `done` pulse. A start seen while busy has no effect. `mem_rd` and `mem_wr` are never high together, and both are low while idle.
- R12: All address sums, including `start_addr`, patch addresses and `next_ptr`, wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin processing one record (taken only when idle) |
| base_addr | input | 16 | Destination base address |
| src_addr | input | 16 | Address of the record's first byte |
| link_in | input | 1 | Incoming link flag |
| fault_in | input | 1 | Incoming fault flag |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data is returned in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Record in progress |
| done | output | 1 | One-cycle completion pulse |
| start_addr | output | 16 | Relocated target address |
| next_ptr | output | 16 | Address of the byte following the record |
| flag_v | output | 1 | Value flag |
| flag_l | output | 1 | Link flag |
| flag_f | output | 1 | Fault flag |

## Verification
The bench targets the corner cases in the flag logic. An end record must keep the incoming fault flag. An empty data record must still test its check byte. An odd-length relocation must abort before any write. A design that treated these cases alike would either raise a fault wrongly or let a bad check byte through.

For patch records, the bench places words at several offsets and compares both the order of the written bytes and the final memory image. A design that swapped the byte order, reused a stale base, or wrote the low byte first would leave a different image or sequence.

Wrap-around is tested with a base near the top of the address space and with a record that straddles the top of memory. A design with a carry leak would report the wrong start address or next-record pointer.

// File: rtl/objrec_pkg.sv
package objrec_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t TYP_DATA = 8'h00;
  localparam byte_t TYP_ADD  = 8'h01;
  localparam byte_t TYP_SUB  = 8'hFF;
  localparam byte_t TYP_END  = 8'h80;

  typedef enum logic [2:0] {RC_DATA, RC_ADD, RC_SUB, RC_END, RC_BAD} rec_cls_e;

  typedef enum logic [4:0] {
    ST_IDLE, ST_H0, ST_H1, ST_H2, ST_H3, ST_DEC,
    ST_CPY_RD, ST_CPY_WR,
    ST_OFH, ST_OFL, ST_WHI, ST_WLO, ST_WRH, ST_WRL,
    ST_CKRD, ST_CKCHK, ST_FIN
  } st_e;

  function automatic rec_cls_e classify(byte_t t);
    case (t)
      TYP_DATA: return RC_DATA;
      TYP_ADD:  return RC_ADD;
      TYP_SUB:  return RC_SUB;
      TYP_END:  return RC_END;
      default:  return RC_BAD;
    endcase
  endfunction

  function automatic addr_t target_addr(addr_t base, byte_t hi, byte_t lo);
    return base + {hi, lo};
  endfunction

  function automatic addr_t reloc_word(addr_t w, addr_t b, logic sub);
    return sub ? (w - b) : (w + b);
  endfunction

  function automatic byte_t csum_step(byte_t s, byte_t d);
    return s + d;
  endfunction

endpackage

// File: rtl/objrec_ctrl.sv
module objrec_ctrl
  import objrec_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  rec_cls_e cls,
  input  logic     len_zero,
  input  logic     len_odd,
  input  logic     cnt_one,
  input  logic     cnt_two,
  output st_e      st
);

  st_e nx;

  always_comb begin
    nx = st;
    case (st)
      ST_IDLE:   if (start) nx = ST_H0;
      ST_H0:     nx = ST_H1;
      ST_H1:     nx = ST_H2;
      ST_H2:     nx = ST_H3;
      ST_H3:     nx = ST_DEC;
      ST_DEC: begin
        case (cls)
          RC_DATA:        nx = len_zero ? ST_CKRD : ST_CPY_RD;
          RC_ADD, RC_SUB: nx = len_odd ? ST_FIN : (len_zero ? ST_CKRD : ST_OFH);
          default:        nx = ST_FIN;
        endcase
      end
      ST_CPY_RD: nx = ST_CPY_WR;
      ST_CPY_WR: nx = cnt_one ? ST_CKRD : ST_CPY_RD;
      ST_OFH:    nx = ST_OFL;
      ST_OFL:    nx = ST_WHI;
      ST_WHI:    nx = ST_WLO;
      ST_WLO:    nx = ST_WRH;
      ST_WRH:    nx = ST_WRL;
      ST_WRL:    nx = cnt_two ? ST_CKRD : ST_OFH;
      ST_CKRD:   nx = ST_CKCHK;
      ST_CKCHK:  nx = ST_FIN;
      ST_FIN:    nx = ST_IDLE;
      default:   nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nx;
  end

endmodule

// File: rtl/objrec_csum.sv
module objrec_csum
  import objrec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  add,
  input  byte_t din,
  output byte_t sum,
  output byte_t sum_nx
);

  assign sum_nx = csum_step(sum, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (add) sum <= sum_nx;
  end

endmodule

// File: rtl/objrec_patch.sv
module objrec_patch
  import objrec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cap_hi,
  input  logic  commit,
  input  byte_t din,
  input  addr_t base,
  input  logic  sub,
  output byte_t wr_hi,
  output byte_t wr_lo
);

  byte_t hi_q;
  byte_t lo_q;
  addr_t word_nx;

  // Old word = captured high byte with the low byte arriving now.
  assign word_nx = reloc_word({hi_q, din}, base, sub);
  assign wr_hi   = word_nx[ADDR_W-1:BYTE_W];
  assign wr_lo   = lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (cap_hi) hi_q <= din;
      if (commit) lo_q <= word_nx[BYTE_W-1:0];
    end
  end

endmodule

// File: rtl/objrec_loader.sv
module objrec_loader
  import objrec_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] base_addr,
  input  logic [15:0] src_addr,
  input  logic        link_in,
  input  logic        fault_in,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] start_addr,
  output logic [15:0] next_ptr,
  output logic        flag_v,
  output logic        flag_l,
  output logic        flag_f
);

  st_e      st;
  rec_cls_e cls;
  addr_t    base_q, rp_q, wp_q, pa_q, start_q;
  byte_t    type_q, len_q, ahi_q, offh_q, cnt_q;
  logic     l_in_q, f_in_q, v_q, l_q, f_q;
  byte_t    sum_q, sum_nx;
  byte_t    patch_hi, patch_lo;
  addr_t    tgt_nx, pa_nx;

  // Named internal events, used by the bound checker.
  logic rd_stream, csum_clr, csum_add;
  logic ev_end, ev_hdr_fault, ev_ck_bad, ev_patch_hi;

  assign cls    = classify(type_q);
  assign tgt_nx = target_addr(base_q, ahi_q, mem_rdata);
  assign pa_nx  = target_addr(base_q, offh_q, mem_rdata);

  objrec_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cls      (cls),
    .len_zero (len_q == '0),
    .len_odd  (len_q[0]),
    .cnt_one  (cnt_q == byte_t'(1)),
    .cnt_two  (cnt_q == byte_t'(2)),
    .st       (st)
  );

  assign csum_clr = (st == ST_IDLE) && start;
  assign csum_add = (st inside {ST_H1, ST_H2, ST_H3, ST_DEC, ST_CPY_WR, ST_OFL, ST_WHI, ST_CKCHK});

  objrec_csum u_csum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (csum_clr),
    .add    (csum_add),
    .din    (mem_rdata),
    .sum    (sum_q),
    .sum_nx (sum_nx)
  );

  objrec_patch u_patch (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_hi (st == ST_WLO),
    .commit (st == ST_WRH),
    .din    (mem_rdata),
    .base   (base_q),
    .sub    (cls == RC_SUB),
    .wr_hi  (patch_hi),
    .wr_lo  (patch_lo)
  );

  assign rd_stream    = (st inside {ST_H0, ST_H1, ST_H2, ST_H3, ST_CPY_RD, ST_OFH, ST_OFL, ST_CKRD});
  assign ev_end       = (st == ST_DEC) && (cls == RC_END);
  assign ev_hdr_fault = (st == ST_DEC) && ((cls == RC_BAD) ||
                        (((cls == RC_ADD) || (cls == RC_SUB)) && len_q[0]));
  assign ev_ck_bad    = (st == ST_CKCHK) && (sum_nx != '0);
  assign ev_patch_hi  = (st == ST_WRH);

  // Memory port steering.
  always_comb begin
    mem_addr  = rp_q;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_wdata = '0;
    if (rd_stream) begin
      mem_rd = 1'b1;
    end else begin
      case (st)
        ST_CPY_WR: begin mem_wr = 1'b1; mem_addr = wp_q;             mem_wdata = mem_rdata; end
        ST_WHI:    begin mem_rd = 1'b1; mem_addr = pa_nx;            end
        ST_WLO:    begin mem_rd = 1'b1; mem_addr = pa_q + addr_t'(1); end
        ST_WRH:    begin mem_wr = 1'b1; mem_addr = pa_q;             mem_wdata = patch_hi; end
        ST_WRL:    begin mem_wr = 1'b1; mem_addr = pa_q + addr_t'(1); mem_wdata = patch_lo; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      rp_q    <= '0;
      wp_q    <= '0;
      pa_q    <= '0;
      start_q <= '0;
      type_q  <= '0;
      len_q   <= '0;
      ahi_q   <= '0;
      offh_q  <= '0;
      cnt_q   <= '0;
      l_in_q  <= 1'b0;
      f_in_q  <= 1'b0;
      v_q     <= 1'b0;
      l_q     <= 1'b0;
      f_q     <= 1'b0;
    end else begin
      if (csum_clr) begin
        base_q <= base_addr;
        rp_q   <= src_addr;
        l_in_q <= link_in;
        f_in_q <= fault_in;
      end
      if (rd_stream) rp_q <= rp_q + addr_t'(1);
      case (st)
        ST_H1: type_q <= mem_rdata;
        ST_H2: len_q  <= mem_rdata;
        ST_H3: ahi_q  <= mem_rdata;
        ST_DEC: begin
          start_q <= tgt_nx;
          wp_q    <= tgt_nx;
          cnt_q   <= len_q;
          if (cls == RC_END) begin
            v_q <= 1'b1;
            l_q <= 1'b1;
            f_q <= f_in_q;
          end else if (ev_hdr_fault) begin
            v_q <= 1'b0;
            l_q <= l_in_q;
            f_q <= 1'b1;
          end else begin
            v_q <= (cls == RC_DATA) && (len_q == '0);
            l_q <= l_in_q;
            f_q <= f_in_q;
          end
        end
        ST_CPY_WR: begin
          wp_q  <= wp_q + addr_t'(1);
          cnt_q <= cnt_q - byte_t'(1);
        end
        ST_OFL:   offh_q <= mem_rdata;
        ST_WHI:   pa_q   <= pa_nx;
        ST_WRL:   cnt_q  <= cnt_q - byte_t'(2);
        ST_CKCHK: f_q    <= f_in_q | (sum_nx != '0);
        default: ;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign done       = (st == ST_FIN);
  assign start_addr = start_q;
  assign next_ptr   = rp_q;
  assign flag_v     = v_q;
  assign flag_l     = l_q;
  assign flag_f     = f_q;

endmodule

// File: rtl/objrec_loader_chk.sv
module objrec_loader_chk
  import objrec_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  start,
  input logic  busy,
  input logic  done,
  input logic  mem_rd,
  input logic  mem_wr,
  input addr_t mem_addr,
  input logic  flag_v,
  input logic  flag_l,
  input logic  flag_f,
  input logic  ev_end,
  input logic  ev_hdr_fault,
  input logic  ev_ck_bad,
  input logic  ev_patch_hi,
  input logic  f_in_q,
  input addr_t base_q
);

  a_r11_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> (busy && $stable(base_q)));

  a_r2_end_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (done && flag_v && flag_l && (flag_f == f_in_q)));

  a_r6_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr_fault |=> (done && flag_f && !flag_v && !mem_wr));

  a_r5_check_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ck_bad |=> (done && flag_f));

  a_r7_patch_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ev_patch_hi |-> mem_wr ##1 (mem_wr && (mem_addr == addr_t'($past(mem_addr) + addr_t'(1)))));

endmodule

bind objrec_loader objrec_loader_chk u_chk (.*);

// File: tb/test_objrec_loader.sv
module test_objrec_loader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] base_addr = '0, src_addr = '0;
  logic        link_in = 1'b0, fault_in = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done;
  logic [15:0] start_addr, next_ptr;
  logic        flag_v, flag_l, flag_f;

  always #4 clk = ~clk;

  objrec_loader i_objrec_loader (.*);

  // Bench memory (4 KiB, address folded) plus a loader side door.
  logic [7:0]  mem  [0:4095];
  logic [7:0]  refm [0:4095];
  logic [15:0] wa [0:255];
  logic [7:0]  wd [0:255];
  int          nw = 0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_a = '0;
  logic [7:0]  ld_d = '0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    if (mem_wr) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      wa[nw[7:0]] <= mem_addr;
      wd[nw[7:0]] <= mem_wdata;
      nw <= nw + 1;
    end
  end

  int checks = 0, errors = 0;
  logic [15:0] ewa [0:255];
  logic [7:0]  ewd [0:255];
  int          enw;
  logic [15:0] e_start, e_next;
  logic        e_v, e_l, e_f;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_a = a[11:0]; ld_d = d;
    refm[a[11:0]] = d;
  endtask

  function automatic logic [15:0] rel_add(input logic [15:0] w, input logic [15:0] b);
    return w + b;
  endfunction

  function automatic logic [15:0] rel_sub(input logic [15:0] w, input logic [15:0] b);
    return w + (~b) + 16'd1;
  endfunction

  // Lay a record into memory and compute every expected result.
  task automatic prep(input logic [7:0] typ, input logic [7:0] len, input logic [15:0] hdr,
                      input logic [15:0] base, input logic [15:0] src,
                      input logic lin, input logic fin, input logic corrupt);
    logic [7:0] pl [0:63];
    logic [7:0] s;
    logic       reloc, odd;
    reloc = (typ == 8'h01) || (typ == 8'hFF);
    odd   = len[0];
    s = typ + len + hdr[15:8] + hdr[7:0];
    put(src, typ); put(src + 16'd1, len); put(src + 16'd2, hdr[15:8]); put(src + 16'd3, hdr[7:0]);
    for (int i = 0; i < 64; i++) pl[i] = 8'($urandom);
    if (reloc && !odd) begin
      for (int k = 0; k < len / 2; k++) begin
        logic [15:0] off;
        off = 16'(k * 8 + ($urandom % 3) * 2);
        pl[2*k] = off[15:8]; pl[2*k+1] = off[7:0];
      end
    end
    if (typ != 8'h80) begin
      for (int i = 0; i < len; i++) begin
        put(src + 16'd4 + 16'(i), pl[i]);
        s = s + pl[i];
      end
      put(src + 16'd4 + 16'(len), (8'd0 - s) + (corrupt ? 8'd1 : 8'd0));
    end
    @(negedge clk); ld_en = 1'b0;
    e_start = base + hdr;
    enw = 0;
    e_l = lin;
    e_v = 1'b0;
    if (typ == 8'h80) begin
      e_v = 1'b1; e_l = 1'b1; e_f = fin; e_next = src + 16'd4;
    end else if ((typ != 8'h00 && !reloc) || (reloc && odd)) begin
      e_f = 1'b1; e_next = src + 16'd4;
    end else begin
      e_f = fin | corrupt;
      e_next = src + 16'd5 + 16'(len);
      if (typ == 8'h00) begin
        e_v = (len == 0);
        for (int i = 0; i < len; i++) begin
          ewa[enw] = e_start + 16'(i); ewd[enw] = pl[i]; enw++;
          refm[ewa[enw-1][11:0]] = pl[i];
        end
      end else begin
        for (int k = 0; k < len / 2; k++) begin
          logic [15:0] pa, w, nv;
          pa = base + {pl[2*k], pl[2*k+1]};
          w  = {refm[pa[11:0]], refm[12'(pa[11:0] + 12'd1)]};
          nv = (typ == 8'h01) ? rel_add(w, base) : rel_sub(w, base);
          ewa[enw] = pa;          ewd[enw] = nv[15:8]; enw++;
          ewa[enw] = pa + 16'd1;  ewd[enw] = nv[7:0];  enw++;
          refm[pa[11:0]] = nv[15:8];
          refm[12'(pa[11:0] + 12'd1)] = nv[7:0];
        end
      end
    end
  endtask

  task automatic run(input logic [15:0] base, input logic [15:0] src, input logic lin,
                     input logic fin, input logic poke, input string tag);
    int nw0, cyc, bad;
    @(negedge clk);
    base_addr = base; src_addr = src; link_in = lin; fault_in = fin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nw0 = nw;
    chk(busy === 1'b1, "R11 busy after start", int'(busy), 1);
    if (poke) begin
      @(negedge clk); start = 1'b1; base_addr = base ^ 16'h0F0F; link_in = ~lin; fault_in = ~fin;
      @(negedge clk); start = 1'b0; base_addr = base; link_in = lin; fault_in = fin;
    end
    cyc = 0;
    while (done !== 1'b1 && cyc < 3000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1, "R11 done reached", int'(done), 1);
    chk(start_addr === e_start, "R1 start address", int'(start_addr), int'(e_start));
    chk(next_ptr === e_next, {tag, " R9 next pointer"}, int'(next_ptr), int'(e_next));
    chk(flag_v === e_v, {tag, " flag V"}, int'(flag_v), int'(e_v));
    chk(flag_l === e_l, {tag, " flag L"}, int'(flag_l), int'(e_l));
    chk(flag_f === e_f, {tag, " flag F"}, int'(flag_f), int'(e_f));
    chk((nw - nw0) == enw, {tag, " write count"}, nw - nw0, enw);
    bad = -1;
    for (int i = 0; i < enw && i < 256; i++)
      if (bad < 0 && (wa[8'(nw0 + i)] !== ewa[i] || wd[8'(nw0 + i)] !== ewd[i])) bad = i;
    chk(bad < 0, {tag, " write sequence"}, bad < 0 ? 0 : int'(wa[8'(nw0 + bad)]), bad < 0 ? 0 : int'(ewa[bad]));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R11 single-cycle done", int'({done, busy}), 0);
    bad = -1;
    for (int i = 0; i < 4096; i++) if (bad < 0 && mem[i] !== refm[i]) bad = i;
    chk(bad < 0, {tag, " R3 memory image"}, bad, -1);
  endtask

  task automatic main_seq();
    for (int i = 0; i < 4096; i++) put(16'(i), 8'($urandom));
    @(negedge clk); ld_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_rd === 1'b0 && mem_wr === 1'b0,
        "R11 reset state", int'({busy, done, mem_rd, mem_wr}), 0);
    // R2 end record, incoming fault kept
    prep(8'h80, 8'd5, 16'h0010, 16'h1234, 16'h0100, 1'b0, 1'b1, 1'b0);
    run(16'h1234, 16'h0100, 1'b0, 1'b1, 1'b0, "R2");
    // R2 / R12 end record straddling top of memory
    prep(8'h80, 8'd0, 16'hFFF0, 16'h0020, 16'hFFFE, 1'b1, 1'b0, 1'b0);
    run(16'h0020, 16'hFFFE, 1'b1, 1'b0, 1'b0, "R12");
    // R4 empty data record, good and bad check byte
    prep(8'h00, 8'd0, 16'h0040, 16'h0900, 16'h0120, 1'b1, 1'b0, 1'b0);
    run(16'h0900, 16'h0120, 1'b1, 1'b0, 1'b0, "R4");
    prep(8'h00, 8'd0, 16'h0040, 16'h0900, 16'h0120, 1'b0, 1'b0, 1'b1);
    run(16'h0900, 16'h0120, 1'b0, 1'b0, 1'b0, "R5 empty");
    // R3 data copy, R5 bad check on data
    prep(8'h00, 8'd17, 16'h0033, 16'h0880, 16'h0140, 1'b0, 1'b0, 1'b0);
    run(16'h0880, 16'h0140, 1'b0, 1'b0, 1'b0, "R3");
    prep(8'h00, 8'd4, 16'h0101, 16'h0880, 16'h0180, 1'b1, 1'b0, 1'b1);
    run(16'h0880, 16'h0180, 1'b1, 1'b0, 1'b0, "R5");
    // R7 add, R8 subtract
    prep(8'h01, 8'd10, 16'h0500, 16'h0A10, 16'h0200, 1'b0, 1'b0, 1'b0);
    run(16'h0A10, 16'h0200, 1'b0, 1'b0, 1'b0, "R7");
    prep(8'hFF, 8'd8, 16'h0700, 16'h0C37, 16'h0240, 1'b1, 1'b0, 1'b0);
    run(16'h0C37, 16'h0240, 1'b1, 1'b0, 1'b0, "R8");
    // R6 odd relocation length
    prep(8'h01, 8'd5, 16'h0000, 16'h0A00, 16'h0280, 1'b1, 1'b0, 1'b0);
    run(16'h0A00, 16'h0280, 1'b1, 1'b0, 1'b0, "R6");
    prep(8'hFF, 8'd3, 16'h0000, 16'h0A00, 16'h0280, 1'b0, 1'b0, 1'b0);
    run(16'h0A00, 16'h0280, 1'b0, 1'b0, 1'b0, "R6 sub");
    // R10 unknown type
    prep(8'h42, 8'd2, 16'h0010, 16'h0A00, 16'h02C0, 1'b1, 1'b0, 1'b0);
    run(16'h0A00, 16'h02C0, 1'b1, 1'b0, 1'b0, "R10");
    // R12 target wraps past the top of the address space
    prep(8'h00, 8'd3, 16'h1900, 16'hF000, 16'h0300, 1'b0, 1'b0, 1'b0);
    run(16'hF000, 16'h0300, 1'b0, 1'b0, 1'b0, "R12 wrap");
    // R11 start while busy is ignored
    prep(8'h01, 8'd4, 16'h0022, 16'h0B00, 16'h0320, 1'b0, 1'b0, 1'b0);
    run(16'h0B00, 16'h0320, 1'b0, 1'b0, 1'b1, "R11 restart");
    // Constrained random records
    for (int n = 0; n < 40; n++) begin
      logic [7:0]  t, l;
      logic [15:0] b, s, h;
      logic        li, fi, cr;
      int          pick;
      pick = $urandom % 4;
      b  = 16'h0800 + 16'($urandom % 16'h0300);
      s  = 16'h0100 + 16'($urandom % 16'h0200);
      li = 1'($urandom); fi = 1'($urandom); cr = (($urandom % 5) == 0);
      if (pick == 0) begin
        t = 8'h00; l = 8'($urandom % 24); h = 16'($urandom % 16'h0200);
      end else if (pick == 3) begin
        t = 8'h80; l = 8'($urandom); h = 16'($urandom);
      end else begin
        t = (pick == 1) ? 8'h01 : 8'hFF;
        l = 8'(2 * (1 + $urandom % 8)) + ((($urandom % 6) == 0) ? 8'd1 : 8'd0);
        h = 16'($urandom);
      end
      prep(t, l, h, b, s, li, fi, cr);
      run(b, s, li, fi, 1'b0, (pick == 0) ? "R3 rnd" : (pick == 1) ? "R7 rnd" : (pick == 2) ? "R8 rnd" : "R2 rnd");
    end
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    fork
      main_seq();
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R11 watchdog expired", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule